// File: doc/BRIEF.md
# Auxiliary Peripheral Interrupt Aggregator

This block is the top-level register window of an auxiliary peripheral group. It owns two small registers, a pending-interrupt register that mirrors the level of three interrupt lines from sub-peripherals, and an enable register. From these two registers it produces one combined interrupt line towards the system interrupt controller.

The same enable register also opens or closes the address window of an attached UART sub-block. Any access at byte offset 0x40 or above in the 0x100-byte window goes to that sub-block's own register port, with the offset rebased so that 0x40 appears as 0. While the window is closed, forwarded reads return zero and forwarded writes never reach the sub-block.

The bus side is a simple 32-bit request port with one request per cycle. Read data comes back registered, one cycle after the request, together with a valid strobe.

Top module: `aux_irq_hub`

## Requirements
- R1: After reset the pending and enable registers are zero, `irq_out`, `uart_en` and `rsp_valid` are low, and the UART window is closed.
- R2: Each bit n (n = 0..2) of the pending register follows the level of `irq_src[n]` with a one-cycle delay. A read at offset 0x00 returns the pending register in bits 2:0 and zeros in bits 31:3.
- R3: A write of 0 or 1 to offset 0x04 loads the enable register. A read at 0x04 returns it in bits 2:0 with zeros above. `uart_en` equals enable bit 0, which is the bit of the UART interrupt line `irq_src[0]`.
- R4: A write to offset 0x04 whose 32-bit value is greater than 1 leaves the enable register and `uart_en` unchanged.
- R5: `irq_out` is registered. In the cycle after any input or register change it is high exactly when the pending register and the enable register share a set bit.
- R6: When `uart_en` is high, a request at an offset of 0x40 or above asserts `sub_valid` in the same cycle. `sub_addr` carries the offset minus 0x40, and `sub_write` and `sub_wdata` are passed through. A read returns `sub_rdata` as sampled in that cycle.
- R7: When `uart_en` is low, requests at offsets of 0x40 or above leave `sub_valid` low, and their reads return zero.
- R8: Reads at undefined offsets below 0x40 return zero, and writes to them have no effect. Writes to the pending register at 0x00 have no effect.
- R9: Every read request produces `rsp_valid` high with its data exactly one cycle later. Write requests produce no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 3 | Level interrupt lines from sub-peripherals, bit 0 from the UART |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| sub_valid | output | 1 | Request forwarded to the UART sub-block |
| sub_write | output | 1 | Forwarded write flag |
| sub_addr | output | 8 | Rebased offset for the sub-block |
| sub_wdata | output | 32 | Forwarded write data |
| sub_rdata | input | 32 | Sub-block read data, valid in the request cycle |
| uart_en | output | 1 | UART window enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: three interrupt lines, an 8-bit byte offset, a 32-bit data path and the sub-block base at 0x40. With these values the whole window can be exercised, from the two registers and the undefined gap to the last forwarded byte at 0xFF. They also leave the two upper enable bits permanently unreachable, so pending lines 1 and 2 can be shown never to raise the combined interrupt. A stand-in sub-block in the bench returns a data word derived from the rebased offset, which makes the rebasing visible in the read data.

// File: rtl/aux_hub_pkg.sv
package aux_hub_pkg;

    // Register offsets inside the window (byte addresses)
    localparam int unsigned PEND_OFS = 'h00;
    localparam int unsigned EN_OFS   = 'h04;

    // Which part of the window a request falls in
    typedef enum logic [1:0] {
        RGN_PEND = 2'd0,
        RGN_EN   = 2'd1,
        RGN_SUB  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

endpackage

// File: rtl/aux_hub_decode.sv
module aux_hub_decode
    import aux_hub_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SUB_BASE = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] sub_ofs
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SUB_BASE);
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

    always_comb begin
        if (addr >= BASE_A) begin
            region = RGN_SUB;
        end else if (addr == PEND_A) begin
            region = RGN_PEND;
        end else if (addr == EN_A) begin
            region = RGN_EN;
        end else begin
            region = RGN_NONE;
        end
        sub_ofs = addr - BASE_A;
    end
endmodule

// File: rtl/aux_hub_irq.sv
module aux_hub_irq #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en_next,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               irq_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    // Pending bits follow the line levels; the combined line is formed
    // from the values the registers will hold after this edge.
    always_comb begin
        st_d      = st_q;
        st_d.pend = src;
        st_d.irq  = |(src & en_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/aux_hub_regs.sv
module aux_hub_regs
    import aux_hub_pkg::*;
#(
    parameter int NUM_SRC  = 3,
    parameter int DATA_W   = 32,
    parameter int UART_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  region_e            region,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [DATA_W-1:0]  sub_rdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] en_d,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata
);
    localparam logic [DATA_W-1:0] EN_MAX = DATA_W'(1);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_en_ok;
    logic    win_open;

    assign win_open = st_q.en[UART_BIT];
    assign wr_en_ok = req_valid && req_write && (region == RGN_EN)
                      && (req_wdata <= EN_MAX);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req_valid && !req_write;
        st_d.rdata  = '0;
        if (req_valid && !req_write) begin
            unique case (region)
                RGN_PEND: st_d.rdata = DATA_W'(pend);
                RGN_EN:   st_d.rdata = DATA_W'(st_q.en);
                RGN_SUB:  st_d.rdata = win_open ? sub_rdata : '0;
                default:  st_d.rdata = '0;
            endcase
        end
        if (wr_en_ok) begin
            st_d.en = req_wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q      = st_q.en;
    assign en_d      = st_d.en;
    assign rsp_valid = st_q.rvalid;
    assign rsp_rdata = st_q.rdata;
endmodule

// File: rtl/aux_irq_hub.sv
module aux_irq_hub
    import aux_hub_pkg::*;
#(
    parameter int NUM_SRC  = 3,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SUB_BASE = 'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               sub_valid,
    output logic               sub_write,
    output logic [ADDR_W-1:0]  sub_addr,
    output logic [DATA_W-1:0]  sub_wdata,
    input  logic [DATA_W-1:0]  sub_rdata,
    output logic               uart_en,
    output logic               irq_out
);
    localparam int UART_BIT = 0;

    region_e            region;
    logic [ADDR_W-1:0]  sub_ofs;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_d;

    aux_hub_decode #(
        .ADDR_W   (ADDR_W),
        .SUB_BASE (SUB_BASE)
    ) u_dec (
        .addr    (req_addr),
        .region  (region),
        .sub_ofs (sub_ofs)
    );

    aux_hub_regs #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .UART_BIT (UART_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .region    (region),
        .pend      (pend_q),
        .sub_rdata (sub_rdata),
        .en_q      (en_q),
        .en_d      (en_d),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    aux_hub_irq #(
        .NUM_SRC (NUM_SRC)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (irq_src),
        .en_next (en_d),
        .pend_q  (pend_q),
        .irq_q   (irq_out)
    );

    assign uart_en   = en_q[UART_BIT];
    assign sub_valid = req_valid && (region == RGN_SUB) && uart_en;
    assign sub_write = req_write;
    assign sub_addr  = sub_ofs;
    assign sub_wdata = req_wdata;
endmodule

// File: rtl/aux_irq_hub_chk.sv
module aux_irq_hub_chk #(
    parameter int NUM_SRC  = 3,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SUB_BASE = 'h40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               rsp_valid,
    input logic               sub_valid,
    input logic [ADDR_W-1:0]  sub_addr,
    input logic               uart_en,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] en_q
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SUB_BASE);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(4);
    localparam logic [DATA_W-1:0] ONE_D  = DATA_W'(1);

    // R2: pending bits mirror the lines one cycle later
    p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(irq_src)));

    // R3: only bit 0 of the enable register can ever be set
    p_en_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q >> 1) == '0);

    // R4: an out-of-range enable write changes nothing
    p_bad_en_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == EN_A && req_wdata > ONE_D)
        |=> ($stable(en_q) && $stable(uart_en)));

    // R5: combined line tracks lines and enable with one register stage
    p_irq_combine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == |($past(irq_src) & en_q)));

    // R6: a forwarded request carries the rebased offset
    p_sub_rebase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (req_addr >= BASE_A && sub_addr == req_addr - BASE_A));

    // R7: no forwarding while the window is closed
    p_sub_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> uart_en);

    // R9: every read is answered in the next cycle, writes never are
    p_rsp_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid == !$past(req_write)));
endmodule

bind aux_irq_hub aux_irq_hub_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SUB_BASE (SUB_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .sub_valid (sub_valid),
    .sub_addr  (sub_addr),
    .uart_en   (uart_en),
    .irq_out   (irq_out),
    .pend_q    (pend_q),
    .en_q      (en_q)
);

// File: tb/test_aux_irq_hub.sv
module test_aux_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_src = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        sub_valid;
    logic        sub_write;
    logic [7:0]  sub_addr;
    logic [31:0] sub_wdata;
    logic [31:0] sub_rdata;
    logic        uart_en;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    int unsigned m_pend   = 0;
    int unsigned m_en     = 0;
    bit          m_irq    = 0;
    bit          m_rvalid = 0;
    int unsigned m_rdata  = 0;

    // stand-in sub-block: data tagged with the rebased offset
    assign sub_rdata = 32'h5A00_0000 | {24'h0, sub_addr};

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_irq_hub i_aux_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sub_valid (sub_valid),
        .sub_write (sub_write),
        .sub_addr  (sub_addr),
        .sub_wdata (sub_wdata),
        .sub_rdata (sub_rdata),
        .uart_en   (uart_en),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One clock of stimulus, reference update and comparison.
    task automatic cyc(input string tag, input bit v, input bit w,
                       input int unsigned a, input int unsigned d,
                       input int unsigned s);
        bit          exp_sv;
        int unsigned nrd;
        req_valid = v;
        req_write = w;
        req_addr  = a[7:0];
        req_wdata = d;
        irq_src   = s[2:0];
        #1;
        exp_sv = v && (a >= 'h40) && (m_en[0] == 1'b1);
        check(tag, "sub_valid", sub_valid, exp_sv);
        if (exp_sv) begin
            check(tag, "sub_addr", sub_addr, a - 'h40);
            check(tag, "sub_write", sub_write, w);
            check(tag, "sub_wdata", sub_wdata, d);
        end
        @(posedge clk);
        nrd = 0;
        if (a == 'h00) nrd = m_pend;
        else if (a == 'h04) nrd = m_en;
        else if (a >= 'h40 && m_en[0]) nrd = 32'h5A00_0000 | (a - 'h40);
        m_rvalid = v && !w;
        m_rdata  = m_rvalid ? nrd : 0;
        if (v && w && a == 'h04 && d <= 1) m_en = d;
        m_pend = s & 7;
        m_irq  = (m_pend & m_en) != 0;
        @(negedge clk);
        check(tag, "irq_out", irq_out, m_irq);
        check(tag, "uart_en", uart_en, m_en[0]);
        check(tag, "rsp_valid", rsp_valid, m_rvalid);
        if (m_rvalid) check(tag, "rsp_rdata", rsp_rdata, m_rdata);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check("R1", "irq_out", irq_out, 0);
        check("R1", "uart_en", uart_en, 0);
        check("R1", "rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        cyc("R1", 1, 0, 'h04, 0, 0);
        cyc("R1", 1, 0, 'h00, 0, 0);
        cyc("R1", 1, 0, 'h40, 0, 0);

        // R2: pending mirrors lines, upper bits zero
        cyc("R2", 0, 0, 0, 0, 5);
        cyc("R2", 1, 0, 'h00, 0, 5);
        cyc("R2", 1, 0, 'h00, 0, 2);
        cyc("R2", 1, 0, 'h00, 0, 7);
        cyc("R2", 1, 0, 'h00, 0, 0);

        // R3 / R5: enable and combined line
        cyc("R5", 0, 0, 0, 0, 1);
        cyc("R3", 1, 1, 'h04, 1, 1);
        cyc("R3", 1, 0, 'h04, 0, 1);
        cyc("R5", 0, 0, 0, 0, 6);
        cyc("R5", 0, 0, 0, 0, 7);
        cyc("R5", 1, 1, 'h04, 0, 7);
        cyc("R5", 0, 0, 0, 0, 1);

        // R4: out-of-range enable writes
        cyc("R4", 1, 1, 'h04, 1, 1);
        cyc("R4", 1, 1, 'h04, 2, 1);
        cyc("R4", 1, 1, 'h04, 3, 1);
        cyc("R4", 1, 1, 'h04, 32'hFFFF_FFFF, 0);
        cyc("R4", 1, 0, 'h04, 0, 0);
        cyc("R4", 1, 1, 'h04, 32'h8000_0000, 0);
        cyc("R4", 1, 0, 'h04, 0, 0);

        // R6: forwarding with window open
        cyc("R6", 1, 0, 'h40, 0, 0);
        cyc("R6", 1, 0, 'h7C, 0, 0);
        cyc("R6", 1, 0, 'hFF, 0, 0);
        cyc("R6", 1, 1, 'h44, 32'h1234_5678, 0);
        cyc("R9", 1, 1, 'h80, 32'h0000_00AB, 0);

        // R7: window closed
        cyc("R7", 1, 1, 'h04, 0, 0);
        cyc("R7", 1, 0, 'h40, 0, 0);
        cyc("R7", 1, 1, 'h48, 32'hDEAD_BEEF, 0);
        cyc("R7", 1, 0, 'hFF, 0, 0);

        // R8: undefined offsets and read-only pending
        cyc("R8", 1, 0, 'h08, 0, 3);
        cyc("R8", 1, 0, 'h3C, 0, 3);
        cyc("R8", 1, 1, 'h00, 7, 2);
        cyc("R8", 1, 0, 'h00, 0, 2);
        cyc("R8", 1, 1, 'h08, 1, 2);
        cyc("R8", 1, 1, 'h3C, 1, 2);
        cyc("R8", 1, 0, 'h04, 0, 2);
        cyc("R8", 1, 0, 'h02, 0, 2);

        // mixed traffic: R9 response timing across patterns
        for (int i = 0; i < 200; i++) begin
            int unsigned a;
            a = (i * 37 + 11) % 256;
            if (i % 9 == 0) a = 'h04;
            if (i % 11 == 0) a = 'h00;
            cyc("R9", (i % 5) != 0, (i % 3) == 0, a, (i * 13) % 3, (i * 7) % 8);
        end
        summary();
    end
endmodule